// File: doc/BRIEF.md
# Post-Modify Pointer Address Unit

This unit keeps a small bank of pointer registers and turns one request per cycle into one memory address. A request names a pointer register and an addressing mode. Most modes hand out the pointer as it stands and then step it by one, step it back by one, or move it by a signed 8-bit constant. One mode forms a base-plus-index address without touching the pointer. When the stack option is built in, one register acts as a stack pointer. A push hands out the pointer already raised by one, and a pop hands out the pointer as it stands and then lowers it by one.

Every candidate address and every candidate new pointer value is produced at the same time by separate adders. A final multiplexer then picks one address and one write-back value. The pre-incremented push address therefore goes through the same depth of logic as the post-modify modes. The address, its valid flag and the pointer write-back are registered. They appear in the cycle after the request, and the pointer bank is updated on that same clock edge.

Top module: `ptr_agu_top`

## Requirements
- R1: After reset every pointer register holds 0 and both `addr_valid` and `wb_valid` are low.
- R2: Mode code 0 (step up): `addr_out` is the pointer named by `req_ptr`, and the pointer becomes p+1. Results come one cycle after the request and are reported on `wb_valid`, `wb_ptr` and `wb_data`.
- R3: Mode code 1 (step down): `addr_out` is p and the pointer becomes p-1, wrapping modulo 2^16.
- R4: Mode code 2 (add constant): `addr_out` is p and the pointer becomes p plus `req_imm` read as a signed 8-bit value sign-extended to 16 bits, modulo 2^16.
- R5: Mode code 3 (base plus index): `addr_out` is p + `req_index` modulo 2^16. `wb_valid` stays low and the pointer keeps its value.
- R6: Mode code 4 (push, stack enabled): `req_ptr` is ignored and register 7 is used. `addr_out` is p7+1, and that same value is written back to register 7 in the same cycle.
- R7: Mode code 5 (pop, stack enabled): register 7 is used. `addr_out` is p7 and register 7 becomes p7-1.
- R8: A request in the cycle right after a write-back sees the updated pointer, so back-to-back requests to the same register chain without a gap.
- R9: Mode codes 6 and 7, and any cycle with `req_valid` low, produce no address and no write-back, and they leave every pointer unchanged.
- R10: With `STACK_EN` set to 0, mode codes 4 and 5 act as the unused codes of R9 and leave register 7 unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 3 | Addressing mode code |
| req_ptr | input | 3 | Pointer register number |
| req_imm | input | 8 | Signed constant for mode 2 |
| req_index | input | 16 | Index added in mode 3 |
| addr_out | output | 16 | Issued address |
| addr_valid | output | 1 | `addr_out` holds a valid address |
| wb_valid | output | 1 | A pointer was updated |
| wb_ptr | output | 3 | Register that was updated |
| wb_data | output | 16 | New value of that register |

## Verification
Every result of this unit is due exactly one clock edge after its request: the address, its valid flag, the write-back report and the pointer bank update. A request issued in the following cycle must already see the new pointer value. The bench drives each request at a falling edge and queues its expected outputs, which come from a pointer model kept in the bench. The monitor checks outputs shortly after the next rising edge and removes exactly one queued item per request. As a result, a result that comes one cycle early or one cycle late misaligns with the queue and shows up as a mismatch. The checks include long runs of back-to-back requests, so chained pointer updates are also checked against those same cycle boundaries.

// File: rtl/ptr_agu_pkg.sv
// Shared definitions for the post-modify pointer address unit.
// Assumes a 3-bit mode code; the code values are part of the interface.
package ptr_agu_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        AM_STEP_UP   = 3'd0,
        AM_STEP_DOWN = 3'd1,
        AM_ADD_CONST = 3'd2,
        AM_BASE_IDX  = 3'd3,
        AM_PUSH      = 3'd4,
        AM_POP       = 3'd5,
        AM_UNUSED6   = 3'd6,
        AM_UNUSED7   = 3'd7
    } amode_e;

endpackage

// File: rtl/ptr_agu_regfile.sv
// Pointer register bank: one combinational read port, one synchronous write port.
// Assumes at most one write per cycle; all registers clear on reset.
module ptr_agu_regfile #(
    parameter int NPTR = 8,
    parameter int AW   = 16,
    localparam int PW  = $clog2(NPTR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] rd_idx,
    output logic [AW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [PW-1:0] wr_idx,
    input  logic [AW-1:0] wr_data
);

    logic [AW-1:0] regs [NPTR];

    for (genvar g = 0; g < NPTR; g++) begin : g_reg
        // Hold or update one pointer register.
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs[g] <= '0;
            else if (wr_en && (wr_idx == PW'(g)))
                regs[g] <= wr_data;
        end
    end

    // Read the selected pointer.
    always_comb rd_data = regs[rd_idx];

endmodule

// File: rtl/ptr_agu_cand.sv
// Candidate generator: computes every possible address or new pointer
// value side by side so no adder sits behind the final mode selection.
// Assumes KW < AW; all sums wrap modulo 2^AW.
module ptr_agu_cand #(
    parameter int AW = 16,
    parameter int KW = 8
) (
    input  logic [AW-1:0] ptr_val,
    input  logic [KW-1:0] imm,
    input  logic [AW-1:0] index,
    output logic [AW-1:0] c_inc,
    output logic [AW-1:0] c_dec,
    output logic [AW-1:0] c_add,
    output logic [AW-1:0] c_bix
);

    logic [AW-1:0] imm_ext;

    // Sign-extend the constant to the address width.
    always_comb imm_ext = {{(AW-KW){imm[KW-1]}}, imm};

    // Four independent adders, all fed directly from the pointer.
    always_comb begin
        c_inc = ptr_val + AW'(1);
        c_dec = ptr_val - AW'(1);
        c_add = ptr_val + imm_ext;
        c_bix = ptr_val + index;
    end

endmodule

// File: rtl/ptr_agu_sel.sv
// Mode decode and final selection: picks the register to read, chooses one
// address and one write-back value from the candidates, and registers results.
// Assumes candidates are derived from the register selected by rd_idx.
module ptr_agu_sel
    import ptr_agu_pkg::*;
#(
    parameter int NPTR     = 8,
    parameter int AW       = 16,
    parameter bit STACK_EN = 1'b1,
    localparam int PW      = $clog2(NPTR),
    localparam int SP_IDX  = NPTR - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [MODE_W-1:0] req_mode,
    input  logic [PW-1:0]     req_ptr,
    output logic [PW-1:0]     rd_idx,
    input  logic [AW-1:0]     ptr_val,
    input  logic [AW-1:0]     c_inc,
    input  logic [AW-1:0]     c_dec,
    input  logic [AW-1:0]     c_add,
    input  logic [AW-1:0]     c_bix,
    output logic              wr_en,
    output logic [PW-1:0]     wr_idx,
    output logic [AW-1:0]     wr_data,
    output logic [AW-1:0]     addr_out,
    output logic              addr_valid,
    output logic              wb_valid,
    output logic [PW-1:0]     wb_ptr,
    output logic [AW-1:0]     wb_data
);

    amode_e        mode;
    logic          stack_op;
    logic          n_av;
    logic [AW-1:0] n_addr;
    logic          n_wv;
    logic [AW-1:0] n_wd;

    // Classify the request and steer stack modes to the stack register.
    always_comb begin
        mode     = amode_e'(req_mode);
        stack_op = STACK_EN && ((mode == AM_PUSH) || (mode == AM_POP));
        rd_idx   = stack_op ? PW'(SP_IDX) : req_ptr;
    end

    // Final multiplexer over the precomputed candidates.
    always_comb begin
        n_av   = 1'b0;
        n_addr = ptr_val;
        n_wv   = 1'b0;
        n_wd   = ptr_val;
        if (req_valid) begin
            unique case (mode)
                AM_STEP_UP:   begin n_av = 1'b1; n_wv = 1'b1; n_wd = c_inc; end
                AM_STEP_DOWN: begin n_av = 1'b1; n_wv = 1'b1; n_wd = c_dec; end
                AM_ADD_CONST: begin n_av = 1'b1; n_wv = 1'b1; n_wd = c_add; end
                AM_BASE_IDX:  begin n_av = 1'b1; n_addr = c_bix; end
                AM_PUSH: begin
                    if (stack_op) begin
                        n_av = 1'b1; n_addr = c_inc; n_wv = 1'b1; n_wd = c_inc;
                    end
                end
                AM_POP: begin
                    if (stack_op) begin
                        n_av = 1'b1; n_wv = 1'b1; n_wd = c_dec;
                    end
                end
                default: begin end
            endcase
        end
    end

    // Feed the pointer bank write port.
    always_comb begin
        wr_en   = n_wv;
        wr_idx  = rd_idx;
        wr_data = n_wd;
    end

    // Register the issued address and write-back report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_out   <= '0;
            addr_valid <= 1'b0;
            wb_valid   <= 1'b0;
            wb_ptr     <= '0;
            wb_data    <= '0;
        end else begin
            addr_out   <= n_addr;
            addr_valid <= n_av;
            wb_valid   <= n_wv;
            wb_ptr     <= rd_idx;
            wb_data    <= n_wd;
        end
    end

endmodule

// File: rtl/ptr_agu_top.sv
// Post-modify pointer address unit top: pointer bank, parallel candidate
// adders and final selection. One request per cycle, results one cycle later.
// Assumes the highest-numbered pointer is the stack pointer when STACK_EN=1.
module ptr_agu_top #(
    parameter int NPTR     = 8,
    parameter int AW       = 16,
    parameter int KW       = 8,
    parameter bit STACK_EN = 1'b1,
    localparam int PW      = $clog2(NPTR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [2:0]    req_mode,
    input  logic [PW-1:0] req_ptr,
    input  logic [KW-1:0] req_imm,
    input  logic [AW-1:0] req_index,
    output logic [AW-1:0] addr_out,
    output logic          addr_valid,
    output logic          wb_valid,
    output logic [PW-1:0] wb_ptr,
    output logic [AW-1:0] wb_data
);

    logic [PW-1:0] rd_idx;
    logic [AW-1:0] ptr_val;
    logic [AW-1:0] c_inc, c_dec, c_add, c_bix;
    logic          wr_en;
    logic [PW-1:0] wr_idx;
    logic [AW-1:0] wr_data;

    ptr_agu_regfile #(.NPTR(NPTR), .AW(AW)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_idx  (rd_idx),
        .rd_data (ptr_val),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data)
    );

    ptr_agu_cand #(.AW(AW), .KW(KW)) u_cand (
        .ptr_val (ptr_val),
        .imm     (req_imm),
        .index   (req_index),
        .c_inc   (c_inc),
        .c_dec   (c_dec),
        .c_add   (c_add),
        .c_bix   (c_bix)
    );

    ptr_agu_sel #(.NPTR(NPTR), .AW(AW), .STACK_EN(STACK_EN)) u_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_mode   (req_mode),
        .req_ptr    (req_ptr),
        .rd_idx     (rd_idx),
        .ptr_val    (ptr_val),
        .c_inc      (c_inc),
        .c_dec      (c_dec),
        .c_add      (c_add),
        .c_bix      (c_bix),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_data    (wr_data),
        .addr_out   (addr_out),
        .addr_valid (addr_valid),
        .wb_valid   (wb_valid),
        .wb_ptr     (wb_ptr),
        .wb_data    (wb_data)
    );

endmodule

// File: rtl/ptr_agu_chk.sv
// Protocol checker for ptr_agu_top: relates each request to the registered
// outputs one cycle later. Bound to every instance of the top module.
module ptr_agu_chk #(
    parameter int AW       = 16,
    parameter int KW       = 8,
    parameter int PW       = 3,
    parameter bit STACK_EN = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_valid,
    input logic [2:0]    req_mode,
    input logic [PW-1:0] req_ptr,
    input logic [KW-1:0] req_imm,
    input logic [AW-1:0] addr_out,
    input logic          addr_valid,
    input logic          wb_valid,
    input logic [PW-1:0] wb_ptr,
    input logic [AW-1:0] wb_data
);

    logic [AW-1:0] imm_ext;
    always_comb imm_ext = {{(AW-KW){req_imm[KW-1]}}, req_imm};

    assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 3'd0) |=>
        (addr_valid && wb_valid && wb_ptr == $past(req_ptr) && wb_data == addr_out + AW'(1)));

    assert_step_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 3'd1) |=>
        (addr_valid && wb_valid && wb_ptr == $past(req_ptr) && wb_data == addr_out - AW'(1)));

    assert_add_const_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 3'd2) |=>
        (addr_valid && wb_valid && wb_data == addr_out + $past(imm_ext)));

    assert_base_idx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_mode == 3'd3) |=> (addr_valid && !wb_valid));

    assert_chain_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && req_valid && req_mode == 3'd0 && req_ptr == wb_ptr) |=>
        (addr_out == $past(wb_data)));

    assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_mode[2:1] == 2'b11) |=> (!addr_valid && !wb_valid));

    if (STACK_EN) begin : g_stk
        assert_push_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_mode == 3'd4) |=>
            (addr_valid && wb_valid && wb_ptr == '1 && wb_data == addr_out));

        assert_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && req_mode == 3'd5) |=>
            (addr_valid && wb_valid && wb_ptr == '1 && wb_data == addr_out - AW'(1)));
    end else begin : g_nostk
        assert_no_stack_R10: assert property (@(posedge clk) disable iff (!rst_n)
            (req_valid && (req_mode == 3'd4 || req_mode == 3'd5)) |=>
            (!addr_valid && !wb_valid));
    end

endmodule

bind ptr_agu_top ptr_agu_chk #(.AW(AW), .KW(KW), .PW(PW), .STACK_EN(STACK_EN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_mode   (req_mode),
    .req_ptr    (req_ptr),
    .req_imm    (req_imm),
    .addr_out   (addr_out),
    .addr_valid (addr_valid),
    .wb_valid   (wb_valid),
    .wb_ptr     (wb_ptr),
    .wb_data    (wb_data)
);

// File: tb/ptr_agu_top_bench.sv
// Scoreboard bench: the driver queues expected results from a pointer model,
// the monitor checks them one cycle later on two instances (stack on / off).
module ptr_agu_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [2:0]  req_mode = '0;
    logic [2:0]  req_ptr = '0;
    logic [7:0]  req_imm = '0;
    logic [15:0] req_index = '0;

    logic [15:0] addr_out[2];
    logic        addr_valid[2];
    logic        wb_valid[2];
    logic [2:0]  wb_ptr[2];
    logic [15:0] wb_data[2];

    int total = 0;
    int bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ptr_agu_top u_ptr_agu_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_ptr(req_ptr), .req_imm(req_imm), .req_index(req_index),
        .addr_out(addr_out[0]), .addr_valid(addr_valid[0]), .wb_valid(wb_valid[0]),
        .wb_ptr(wb_ptr[0]), .wb_data(wb_data[0])
    );

    ptr_agu_top #(.STACK_EN(1'b0)) u_ptr_agu_top_nostk (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
        .req_ptr(req_ptr), .req_imm(req_imm), .req_index(req_index),
        .addr_out(addr_out[1]), .addr_valid(addr_valid[1]), .wb_valid(wb_valid[1]),
        .wb_ptr(wb_ptr[1]), .wb_data(wb_data[1])
    );

    typedef struct {
        logic        v[2];
        logic [15:0] a[2];
        logic        wv[2];
        logic [2:0]  wp[2];
        logic [15:0] wd[2];
        string       tag;
    } exp_t;

    exp_t        q[$];
    logic [15:0] mdl[2][8];

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle of stimulus and queue its expected outcome for both instances.
    task automatic drive(input logic v, input logic [2:0] m, input logic [2:0] p,
                         input logic [7:0] k, input logic [15:0] x, input string tag);
        exp_t e;
        @(negedge clk);
        req_valid = v; req_mode = m; req_ptr = p; req_imm = k; req_index = x;
        e.tag = tag;
        for (int s = 0; s < 2; s++) begin
            logic [15:0] cur;
            bit stk;
            stk = (s == 0);
            e.v[s] = 0; e.a[s] = '0; e.wv[s] = 0; e.wp[s] = p; e.wd[s] = '0;
            cur = mdl[s][p];
            if (v) begin
                case (m)
                    3'd0: begin e.v[s] = 1; e.a[s] = cur; e.wv[s] = 1; e.wd[s] = cur + 16'd1; end
                    3'd1: begin e.v[s] = 1; e.a[s] = cur; e.wv[s] = 1; e.wd[s] = cur - 16'd1; end
                    3'd2: begin e.v[s] = 1; e.a[s] = cur; e.wv[s] = 1;
                                e.wd[s] = cur + {{8{k[7]}}, k}; end
                    3'd3: begin e.v[s] = 1; e.a[s] = cur + x; end
                    3'd4: if (stk) begin
                              e.v[s] = 1; e.wv[s] = 1; e.wp[s] = 3'd7;
                              e.a[s] = mdl[s][7] + 16'd1; e.wd[s] = e.a[s];
                          end
                    3'd5: if (stk) begin
                              e.v[s] = 1; e.wv[s] = 1; e.wp[s] = 3'd7;
                              e.a[s] = mdl[s][7]; e.wd[s] = mdl[s][7] - 16'd1;
                          end
                    default: begin end
                endcase
            end
            if (e.wv[s]) mdl[s][e.wp[s]] = e.wd[s];
        end
        q.push_back(e);
    endtask

    // Monitor: one queued item per rising edge, sampled 2 ns after it.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                for (int s = 0; s < 2; s++) begin
                    string t;
                    t = {e.tag, (s == 0) ? " stk" : " nostk"};
                    check({t, " addr_valid"}, {15'd0, addr_valid[s]}, {15'd0, e.v[s]});
                    if (e.v[s]) check({t, " addr"}, addr_out[s], e.a[s]);
                    check({t, " wb_valid"}, {15'd0, wb_valid[s]}, {15'd0, e.wv[s]});
                    if (e.wv[s]) begin
                        check({t, " wb_ptr"}, {13'd0, wb_ptr[s]}, {13'd0, e.wp[s]});
                        check({t, " wb_data"}, wb_data[s], e.wd[s]);
                    end
                end
            end
        end
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 2; s++)
            for (int i = 0; i < 8; i++) mdl[s][i] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        // R1: outputs idle straight after reset
        for (int s = 0; s < 2; s++) begin
            check("R1 reset addr_valid", {15'd0, addr_valid[s]}, 16'd0);
            check("R1 reset wb_valid", {15'd0, wb_valid[s]}, 16'd0);
        end
        // R1 R2: first step-up on each register reads zero
        for (int i = 0; i < 8; i++) drive(1, 3'd0, 3'(i), 8'd0, 16'd0, "R1 R2 step up");
        // R4: positive, negative and extreme constants
        drive(1, 3'd2, 3'd1, 8'd100, 16'd0, "R4 add +100");
        drive(1, 3'd2, 3'd1, 8'hFD, 16'd0, "R4 add -3");
        drive(1, 3'd2, 3'd2, 8'h80, 16'd0, "R4 add -128 wrap");
        drive(1, 3'd2, 3'd4, 8'h7F, 16'd0, "R4 add +127");
        // R3: step down through zero
        drive(1, 3'd1, 3'd3, 8'd0, 16'd0, "R3 step down");
        drive(1, 3'd1, 3'd3, 8'd0, 16'd0, "R3 step down wrap");
        // R5: base plus index, pointer untouched
        drive(1, 3'd3, 3'd1, 8'd9, 16'h0100, "R5 base idx");
        drive(1, 3'd3, 3'd2, 8'd0, 16'h00FF, "R5 base idx wrap");
        drive(1, 3'd0, 3'd1, 8'd0, 16'd0, "R5 pointer unchanged");
        // R6 R7 R8: push ignores req_ptr, chained stack operations
        drive(1, 3'd4, 3'd3, 8'd0, 16'd0, "R6 push");
        drive(1, 3'd4, 3'd0, 8'd0, 16'd0, "R6 R8 push");
        drive(1, 3'd5, 3'd2, 8'd0, 16'd0, "R7 R8 pop");
        drive(1, 3'd5, 3'd7, 8'd0, 16'd0, "R7 R8 pop");
        drive(1, 3'd5, 3'd7, 8'd0, 16'd0, "R7 R8 pop");
        // R10: register 7 seen through step-up differs between instances
        drive(1, 3'd0, 3'd7, 8'd0, 16'd0, "R10 stack reg");
        drive(1, 3'd4, 3'd7, 8'd0, 16'd0, "R10 push");
        drive(1, 3'd5, 3'd1, 8'd0, 16'd0, "R10 pop");
        drive(1, 3'd0, 3'd7, 8'd0, 16'd0, "R10 stack reg after");
        // R9: unused codes and idle cycles change nothing
        drive(1, 3'd6, 3'd2, 8'h11, 16'h1234, "R9 code 6");
        drive(1, 3'd7, 3'd2, 8'h22, 16'h4321, "R9 code 7");
        drive(0, 3'd0, 3'd2, 8'h33, 16'd0, "R9 invalid");
        drive(0, 3'd2, 3'd2, 8'h44, 16'd0, "R9 invalid");
        drive(1, 3'd0, 3'd2, 8'd0, 16'd0, "R9 pointer unchanged");
        // R8: back-to-back chains on one register
        for (int i = 0; i < 4; i++) drive(1, 3'd0, 3'd5, 8'd0, 16'd0, "R8 chain up");
        for (int i = 0; i < 2; i++) drive(1, 3'd1, 3'd5, 8'd0, 16'd0, "R8 chain down");
        drive(1, 3'd2, 3'd5, 8'hF0, 16'd0, "R8 chain add");
        drive(1, 3'd3, 3'd5, 8'd0, 16'h0010, "R8 chain idx");
        // R8: mixed sweep over all modes and registers
        for (int i = 0; i < 96; i++)
            drive(1, 3'(i % 7), 3'((i * 3) % 8), 8'(i * 37), 16'(i * 1013), "R8 sweep");
        drive(0, 3'd0, 3'd0, 8'd0, 16'd0, "R9 tail idle");
        drive(0, 3'd0, 3'd0, 8'd0, 16'd0, "R9 tail idle");
        repeat (3) @(posedge clk);
        #3;
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule